// File: doc/BRIEF.md
# Oscillator Sub-Band Calibration Controller

This controller picks one of 32 oscillator sub-bands so that the oscillator frequency, after the feedback divider, lands next to the phase-detector reference. The search is a five-step binary search, most significant bit first. Each step tries a code, restarts the feedback divider, and lets the divided feedback clock race the reference clock for one reference period. If the reference period ends before any feedback pulse, the feedback is slower and the tried bit is kept. If a feedback pulse arrives first, or in the same cycle as the closing reference pulse, the bit is cleared. A higher band code gives a higher oscillator frequency.

Software starts a run by writing the calibration control register with its trigger bit set. If the auto-restart bit is set, a write to any divider-ratio register also starts a run, since every ratio change needs a new calibration. A run uses seven reference periods:

- one setup period, from the trigger to the first reference pulse;
- five compare windows;
- one finishing period.

While the run is in progress, a busy flag and a force output are high. The force output parks the charge-pump and control-voltage nodes at mid-supply. The reference and feedback clocks reach the block as one-cycle pulses in the system clock domain.

The controller is built from four parts:

- a configuration decoder;
- a sequencer state machine with the states IDLE, SETUP, COMPARE and FINISH;
- a successive-approximation datapath;
- a top level that joins them.

The sequencer moves between its states as follows:

- **IDLE to SETUP:** on a start.
- **SETUP to COMPARE:** at the first reference pulse. This opens the window for bit 4.
- **COMPARE to COMPARE:** at a reference pulse that decides bit 1, 2, 3 or 4. The next window opens.
- **COMPARE to FINISH:** at the reference pulse that decides bit 0.
- **FINISH to IDLE:** at the next reference pulse.
- **Any busy state to SETUP:** on a start. A start takes priority over a reference pulse in the same cycle.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, band_code is 16 (binary 10000), and cal_busy, cal_force and fb_align are all 0.
- R2: A write of cfg_wdata with bit 6 set to address 5 starts a run. From the cycle after the write edge, cal_busy and cal_force are 1 and band_code is 16.
- R3: The final code is found MSB first. A tried bit is kept only if no fb_tick arrives during its window. With a feedback period that falls as the code rises, the result equals the number of codes from 1 to 31 whose feedback period is longer than the reference period.
- R4: If the first fb_tick of a window arrives in the same cycle as the reference pulse that closes the window, the feedback counts as not slower and the bit is cleared.
- R5: cal_busy falls on the 7th reference pulse sampled after the start edge.
- R6: cal_force equals cal_busy in every cycle.
- R7: fb_align pulses for one cycle after each reference pulse that opens a compare window, which gives exactly 5 pulses per run.
- R8: A start while cal_busy is 1 reloads band_code to 16 and begins a new 7-period run.
- R9: Bit 5 of the address-5 register enables auto-restart. While it is set, a write to a divider address (1 to 3) starts a run. While it is clear, such a write does not start one. A write to any other address never starts a run.
- R10: After a run, band_code holds its final value until the next start.
- R11: A write to address 5 with bit 6 clear does not start a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| ref_tick | input | 1 | One-cycle pulse per phase-detector reference period |
| fb_tick | input | 1 | One-cycle pulse per divided feedback period |
| band_code | output | 5 | Sub-band code: the trial code during a run, the result after it |
| cal_busy | output | 1 | Calibration run in progress |
| cal_force | output | 1 | Park charge-pump and control-voltage nodes at mid-supply |
| fb_align | output | 1 | Restart the feedback divider at the start of a window |

## Verification
The bench models the oscillator as a feedback period in clock cycles equal to a base value minus the band code. It then runs the search against bases that give the following results:

- a result in the middle of the range;
- all bits kept, giving 31;
- all bits cleared, giving 0;
- an exact tie on the window edge.

A design that compared in the wrong direction, or that treated a tie as slower, would settle one code off or at the opposite end of the range. The bench counts reference pulses and alignment pulses per run, which catches a run one period short or long. It retriggers in the middle of a run, which exposes a design that ignores the restart or resumes from a stale code. It writes the control register with the trigger bit clear, and writes divider addresses with auto-restart both set and clear, which catches false or missing starts.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_CMP    = 2'd2,
        ST_FINISH = 2'd3
    } cal_state_t;

endpackage

// File: rtl/vbc_cfg_decode.sv
module vbc_cfg_decode #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CAL_ADDR  = 3'd5,
    parameter logic [ADDR_W-1:0] DIV_FIRST = 3'd1,
    parameter logic [ADDR_W-1:0] DIV_LAST  = 3'd3,
    parameter int TRIG_BIT = 6,
    parameter int AUTO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              start,
    output logic              auto_en
);

    logic cal_hit;
    logic div_hit;
    logic auto_q;
    logic unused_wdata;

    assign cal_hit = cfg_we && (cfg_addr == CAL_ADDR);
    assign div_hit = cfg_we && (cfg_addr >= DIV_FIRST) && (cfg_addr <= DIV_LAST);

    // auto-restart enable lives in the calibration control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
        end else if (cal_hit) begin
            auto_q <= cfg_wdata[AUTO_BIT];
        end
    end

    assign start        = (cal_hit && cfg_wdata[TRIG_BIT]) || (div_hit && auto_q);
    assign auto_en      = auto_q;
    assign unused_wdata = ^cfg_wdata;

    // R9
    div_needs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_hit && !auto_en && !cal_hit) |-> !start);

endmodule

// File: rtl/vbc_seq_fsm.sv
module vbc_seq_fsm
    import vbc_pkg::*;
#(
    parameter int CODE_W = 5,
    localparam int IDX_W = $clog2(CODE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ref_tick,
    output logic [IDX_W-1:0] idx,
    output logic             open_win,
    output logic             decide,
    output logic             busy,
    output logic             force_mid
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    cal_state_t       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next-state and bit-index update
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (start) begin
                    st_d = ST_SETUP;
                end else if (ref_tick) begin
                    st_d  = ST_CMP;
                    idx_d = TOP_IDX;
                end
            end
            ST_CMP: begin
                if (start) begin
                    st_d = ST_SETUP;
                end else if (ref_tick) begin
                    if (idx_q == '0) st_d = ST_FINISH;
                    else             idx_d = idx_q - 1'b1;
                end
            end
            ST_FINISH: begin
                if (start)         st_d = ST_SETUP;
                else if (ref_tick) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        force_mid = 1'b1;
        open_win  = 1'b0;
        decide    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                busy      = 1'b0;
                force_mid = 1'b0;
            end
            ST_SETUP: begin
                open_win = ref_tick && !start;
            end
            ST_CMP: begin
                decide   = ref_tick && !start;
                open_win = ref_tick && !start && (idx_q != '0);
            end
            ST_FINISH: begin
            end
            default: begin
                busy      = 1'b0;
                force_mid = 1'b0;
            end
        endcase
    end

    assign idx = idx_q;

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q == ST_SETUP));

    // R5
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FINISH && ref_tick && !start) |=> (st_q == ST_IDLE));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CMP) |-> (idx_q <= TOP_IDX));

endmodule

// File: rtl/vbc_sar_path.sv
module vbc_sar_path #(
    parameter int CODE_W = 5,
    localparam int IDX_W = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              open_win,
    input  logic              decide,
    input  logic              busy,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fb_tick,
    output logic [CODE_W-1:0] code,
    output logic              fb_align
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic fast_q;
    logic align_q;
    logic slow;

    // feedback seen during the open window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (open_win) begin
            fast_q <= 1'b0;
        end else if (fb_tick) begin
            fast_q <= 1'b1;
        end
    end

    // a pulse in the closing cycle counts as not slower
    assign slow = !(fast_q || fb_tick);

    genvar i;
    generate
        for (i = 0; i < CODE_W; i++) begin : g_bit
            localparam logic [IDX_W-1:0] MY_IDX   = IDX_W'(i);
            localparam logic [IDX_W-1:0] ABOVE    = IDX_W'(i + 1);
            localparam logic             INIT_VAL = (i == CODE_W - 1);
            logic b_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    b_q <= INIT_VAL;
                end else if (start) begin
                    b_q <= INIT_VAL;
                end else if (decide && idx == MY_IDX) begin
                    b_q <= slow;
                end else if (decide && idx == ABOVE) begin
                    b_q <= 1'b1;
                end
            end
            assign code[i] = b_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) align_q <= 1'b0;
        else        align_q <= open_win;
    end

    assign fb_align = align_q;

    // R2
    mid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (code == MID_CODE));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(code));

    // R4
    tie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && fb_tick && idx == '0 && !start) |=> !code[0]);

endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
    parameter int CODE_W = 5,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CAL_ADDR  = 3'd5,
    parameter logic [ADDR_W-1:0] DIV_FIRST = 3'd1,
    parameter logic [ADDR_W-1:0] DIV_LAST  = 3'd3,
    parameter int TRIG_BIT = 6,
    parameter int AUTO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ref_tick,
    input  logic              fb_tick,
    output logic [CODE_W-1:0] band_code,
    output logic              cal_busy,
    output logic              cal_force,
    output logic              fb_align
);

    localparam int IDX_W = $clog2(CODE_W + 1);

    logic             start;
    logic             auto_en;
    logic             open_win;
    logic             decide;
    logic [IDX_W-1:0] idx;
    logic             unused_auto;

    vbc_cfg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAL_ADDR(CAL_ADDR),
        .DIV_FIRST(DIV_FIRST), .DIV_LAST(DIV_LAST),
        .TRIG_BIT(TRIG_BIT), .AUTO_BIT(AUTO_BIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .auto_en(auto_en)
    );

    vbc_seq_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick),
        .idx(idx), .open_win(open_win), .decide(decide),
        .busy(cal_busy), .force_mid(cal_force)
    );

    vbc_sar_path #(.CODE_W(CODE_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .start(start), .open_win(open_win),
        .decide(decide), .busy(cal_busy), .idx(idx), .fb_tick(fb_tick),
        .code(band_code), .fb_align(fb_align)
    );

    assign unused_auto = auto_en;

    // R6
    force_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_force == cal_busy);

    // R7
    align_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_align |-> cal_busy);

    // R11
    noop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CAL_ADDR && !cfg_wdata[TRIG_BIT] && !cal_busy) |=> !cal_busy);

endmodule

// File: tb/sim_vco_band_cal.sv
`timescale 1ns/1ps
module sim_vco_band_cal;

    localparam int REF_PER = 40;
    localparam logic [2:0] CAL_A   = 3'd5;
    localparam logic [2:0] DIV_A   = 3'd2;
    localparam logic [2:0] OTHER_A = 3'd0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       ref_tick = 1'b0;
    logic       fb_tick = 1'b0;
    logic [4:0] band_code;
    logic       cal_busy;
    logic       cal_force;
    logic       fb_align;

    int n_chk = 0;
    int n_fail = 0;
    int base = 60;
    int rc = 0;
    int fcnt = 0;
    int fper = 1;
    bit armed = 1'b0;
    int cyc = 0;

    vco_band_cal u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .band_code(band_code), .cal_busy(cal_busy), .cal_force(cal_force),
        .fb_align(fb_align)
    );

    always #2 clk = ~clk;

    // reference pulse train and oscillator/divider model
    always @(negedge clk) begin
        if (!rst_n) begin
            rc = 0;
            ref_tick = 1'b0;
        end else begin
            rc = (rc == REF_PER - 1) ? 0 : rc + 1;
            ref_tick = (rc == REF_PER - 1);
        end
        if (fb_align) begin
            fper = base - int'(band_code);
            fcnt = 1;
            armed = 1'b1;
        end else if (armed) begin
            fcnt++;
        end
        fb_tick = armed && (fcnt == fper);
        if (fb_tick) armed = 1'b0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic int exp_code(int b);
        int n = 0;
        for (int c = 1; c < 32; c++) if (b - c > REF_PER) n++;
        return n;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_done(output int nt, output int na, output int nbad);
        nt = 0; na = 0; nbad = 0;
        for (int k = 0; k < 2000; k++) begin
            @(posedge clk);
            #1;
            if (ref_tick) nt++;
            if (fb_align) na++;
            if (cal_force != cal_busy) nbad++;
            if (!cal_busy) break;
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(cal_busy), 0);
        chk("R1 force", int'(cal_force), 0);
        chk("R1 code", int'(band_code), 16);
        chk("R1 align", int'(fb_align), 0);
    endtask

    task automatic t_run(string req, int b);
        int nt, na, nbad;
        base = b;
        cfg_write(CAL_A, 8'h40);
        chk("R2 busy after trigger", int'(cal_busy), 1);
        chk("R2 force after trigger", int'(cal_force), 1);
        chk("R2 trial code", int'(band_code), 16);
        wait_done(nt, na, nbad);
        chk("R5 reference periods", nt, 7);
        chk("R7 align pulses", na, 5);
        chk("R6 force mismatches", nbad, 0);
        chk(req, int'(band_code), exp_code(b));
    endtask

    task automatic t_hold();
        logic [4:0] keep;
        keep = band_code;
        repeat (3 * REF_PER) @(posedge clk);
        #1;
        chk("R10 code held", int'(band_code), int'(keep));
        chk("R10 busy idle", int'(cal_busy), 0);
    endtask

    task automatic t_noop();
        logic [4:0] keep;
        keep = band_code;
        cfg_write(CAL_A, 8'h00);
        repeat (4) @(posedge clk);
        #1;
        chk("R11 no start busy", int'(cal_busy), 0);
        chk("R11 code unchanged", int'(band_code), int'(keep));
    endtask

    task automatic t_retrig();
        int nt, na, nbad, seen;
        base = 60;
        cfg_write(CAL_A, 8'h40);
        seen = 0;
        while (seen < 3) begin
            @(posedge clk);
            #1;
            if (ref_tick) seen++;
        end
        chk("R8 busy mid run", int'(cal_busy), 1);
        cfg_write(CAL_A, 8'h40);
        chk("R8 reload code", int'(band_code), 16);
        chk("R8 busy after retrigger", int'(cal_busy), 1);
        wait_done(nt, na, nbad);
        chk("R8 periods after retrigger", nt, 7);
        chk("R8 result after retrigger", int'(band_code), exp_code(60));
    endtask

    task automatic t_auto();
        int nt, na, nbad;
        cfg_write(CAL_A, 8'h20);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 enable write no start", int'(cal_busy), 0);
        base = 80;
        cfg_write(DIV_A, 8'h12);
        chk("R9 divider write starts", int'(cal_busy), 1);
        chk("R9 trial code", int'(band_code), 16);
        wait_done(nt, na, nbad);
        chk("R9 auto result", int'(band_code), exp_code(80));
        cfg_write(OTHER_A, 8'h55);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 other address no start", int'(cal_busy), 0);
        cfg_write(CAL_A, 8'h00);
        cfg_write(DIV_A, 8'h34);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 disabled no start", int'(cal_busy), 0);
        chk("R9 disabled code kept", int'(band_code), exp_code(80));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_run("R3 mid result", 60);
        t_hold();
        t_run("R3 all bits kept", 80);
        t_run("R3 all bits cleared", 40);
        t_run("R3 result 16", 57);
        t_run("R4 tie clears bit", 50);
        t_noop();
        t_retrig();
        t_auto();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule